// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block brings a 2048-row fast page mode DRAM out of power-up and keeps its contents alive. After reset it keeps every strobe it drives inactive for a long settling pause. It then runs a fixed number of wake-up refresh cycles and raises an init-done flag. From then on an interval timer produces one refresh obligation per tick, so that all rows are covered inside the retention window.

Each refresh uses the column-strobe-first ordering, in which the device keeps its own row counter. No row address is driven, and the write strobe is held high. The scheduler never takes the memory bus by itself. It raises a request to the access sequencer and starts a cycle only after a grant, which the sequencer gives while the row strobe is inactive. Refresh work that the sequencer defers is counted in a small saturating backlog. A tick that arrives while the backlog is full sets a sticky overflow flag.

All durations are counted in clock cycles and set by parameters. The defaults assume a 100 MHz clock.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low, and for INIT_PAUSE_CYC clock edges after it is released, ras_n and cas_n are 1 and bus_req, init_done and backlog_ovf are 0. bus_req first becomes 1 after exactly INIT_PAUSE_CYC edges.
- R2: After the pause the block runs exactly WAKE_COUNT refresh cycles. init_done rises at the end of the last one and then stays 1 until reset.
- R3: Every refresh drives cas_n low for CAS_LEAD_CYC cycles while ras_n is still 1, and only then drives ras_n low. cas_n stays low for CAS_HOLD_CYC cycles after ras_n falls and returns to 1 while ras_n is still low.
- R4: we_n is 1 in every cycle where ras_n or cas_n is 0.
- R5: ras_n stays low for exactly RAS_LOW_CYC cycles per refresh. It is then high for at least RP_CYC cycles before cas_n falls again.
- R6: Once init_done is 1, one refresh is owed every TICK_CYC cycles, and the first one is owed TICK_CYC cycles after init_done rises. With the grant held at 1, consecutive falls of ras_n are exactly TICK_CYC cycles apart, and every owed refresh is eventually run.
- R7: A refresh starts only in the cycle after bus_grant was sampled 1 while bus_req was 1. Whenever bus_req is 0, ras_n and cas_n are 1. While bus_grant stays 0, no refresh starts and bus_req stays 1 if work is owed.
- R8: Up to BACKLOG_MAX deferred refreshes are kept. When the grant returns, they run back to back, one idle cycle apart. A tick that arrives with a full backlog is dropped and sets backlog_ovf, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_grant | input | 1 | Access sequencer hands the DRAM strobes to this block (row strobe high) |
| bus_req | output | 1 | Refresh work owed or a refresh cycle in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high during refresh |
| init_done | output | 1 | Power-up pause and wake-up refreshes are complete |
| backlog_ovf | output | 1 | Sticky flag: a refresh tick was lost to a full backlog |

## Verification
The hardest situation to reach from the ports is the saturated backlog: a full backlog at the same moment as a ninth tick, with no refresh in flight. The bench builds the block with a short timer. It keeps its own model of tick times, counted from the rise of init_done, so it can withhold the grant from the middle of a tick period for eight and then nine periods. It checks the overflow flag at each of those points. It then counts exactly BACKLOG_MAX refreshes in the burst that follows, before the next tick is due.

// File: rtl/dram_refresh_pkg.sv
// Shared types and helpers for the DRAM refresh scheduler.
package dram_refresh_pkg;

    // Phases of the strobe sequencer.
    typedef enum logic [2:0] {
        RS_PAUSE    = 3'd0,
        RS_IDLE     = 3'd1,
        RS_CAS_LEAD = 3'd2,
        RS_RAS_LOW  = 3'd3,
        RS_PRECHG   = 3'd4
    } rs_state_e;

    // Largest of three cycle counts, used to size a shared phase counter.
    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/refresh_tick_timer.sv
// Interval timer: emits a one-cycle tick every TICK_CYC cycles while enabled.
// Assumes TICK_CYC >= 2. When the timer is disabled, its count returns to zero.
module refresh_tick_timer #(
    parameter int TICK_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(TICK_CYC);

    logic [TW-1:0] cnt_q;

    assign tick = en && (cnt_q == TW'(TICK_CYC - 1));

    // Count enabled cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/refresh_backlog.sv
// Pending-refresh counter: adds one per tick and removes one per accepted refresh.
// Saturates at DEPTH. A tick that finds the counter full with no removal in the
// same cycle is dropped and sets a sticky overflow flag.
// Assumes that take is only asserted while the counter is non-zero.
module refresh_backlog #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic nonzero,
    output logic ovf
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    assign nonzero = (cnt_q != '0);
    assign ovf     = ovf_q;

    // Apply tick and take together; when both arrive, the count is unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case ({tick, take})
                2'b10: begin
                    if (cnt_q == CW'(DEPTH)) ovf_q <= 1'b1;
                    else                     cnt_q <= cnt_q + CW'(1);
                end
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/refresh_strobe_fsm.sv
// Strobe sequencer: holds the power-up pause, then runs the wake-up refreshes and
// the periodic refresh cycles with the column strobe falling before the row strobe.
// Assumes that the access sequencer grants the bus only while the row strobe is
// inactive, and that it leaves the strobes to this block while bus_req is high.
module refresh_strobe_fsm
    import dram_refresh_pkg::*;
#(
    parameter int INIT_PAUSE_CYC = 20000,
    parameter int WAKE_COUNT     = 8,
    parameter int CAS_LEAD_CYC   = 1,
    parameter int CAS_HOLD_CYC   = 2,
    parameter int RAS_LOW_CYC    = 6,
    parameter int RP_CYC         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic backlog_nz,
    input  logic bus_grant,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic take
);
    localparam int PW = $clog2(INIT_PAUSE_CYC + 1);
    localparam int SW = $clog2(max_of3(CAS_LEAD_CYC, RAS_LOW_CYC, RP_CYC) + 1);
    localparam int WW = $clog2(WAKE_COUNT + 1);

    rs_state_e     state_q;
    logic [PW-1:0] pause_q;
    logic [SW-1:0] ph_q;
    logic [WW-1:0] wake_q;
    logic          done_q;
    logic          need;
    logic          start;

    // Work is owed: the remaining wake-up cycles before init, the backlog after it.
    assign need  = done_q ? backlog_nz : (wake_q != '0);
    assign start = (state_q == RS_IDLE) && need && bus_grant;
    assign take  = start && done_q;

    // Strobe decode from the registered phase.
    assign ras_n     = (state_q != RS_RAS_LOW);
    assign cas_n     = !((state_q == RS_CAS_LEAD) ||
                         ((state_q == RS_RAS_LOW) && (ph_q < SW'(CAS_HOLD_CYC))));
    assign we_n      = 1'b1;
    assign bus_req   = ((state_q == RS_IDLE) && need) ||
                       (state_q == RS_CAS_LEAD) || (state_q == RS_RAS_LOW) ||
                       (state_q == RS_PRECHG);
    assign init_done = done_q;

    // Sequence the pause, the strobe phases and the wake-up bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_PAUSE;
            pause_q <= '0;
            ph_q    <= '0;
            wake_q  <= WW'(WAKE_COUNT);
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                RS_PAUSE: begin
                    if (pause_q == PW'(INIT_PAUSE_CYC - 1)) state_q <= RS_IDLE;
                    else                                    pause_q <= pause_q + PW'(1);
                end
                RS_IDLE: begin
                    ph_q <= '0;
                    if (start) begin
                        state_q <= RS_CAS_LEAD;
                        if (!done_q) wake_q <= wake_q - WW'(1);
                    end
                end
                RS_CAS_LEAD: begin
                    if (ph_q == SW'(CAS_LEAD_CYC - 1)) begin
                        ph_q    <= '0;
                        state_q <= RS_RAS_LOW;
                    end else begin
                        ph_q <= ph_q + SW'(1);
                    end
                end
                RS_RAS_LOW: begin
                    if (ph_q == SW'(RAS_LOW_CYC - 1)) begin
                        ph_q    <= '0;
                        state_q <= RS_PRECHG;
                    end else begin
                        ph_q <= ph_q + SW'(1);
                    end
                end
                RS_PRECHG: begin
                    if (ph_q == SW'(RP_CYC - 1)) begin
                        ph_q    <= '0;
                        state_q <= RS_IDLE;
                        if (!done_q && (wake_q == '0)) done_q <= 1'b1;
                    end else begin
                        ph_q <= ph_q + SW'(1);
                    end
                end
                default: state_q <= RS_PAUSE;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the refresh scheduler. It joins the interval timer, the backlog counter
// and the strobe sequencer. The timer runs only after initialisation is complete.
// Assumes CAS_HOLD_CYC < RAS_LOW_CYC and that every cycle count is at least 1.
module dram_refresh_sched #(
    parameter int INIT_PAUSE_CYC = 20000,
    parameter int WAKE_COUNT     = 8,
    parameter int TICK_CYC       = 1560,
    parameter int BACKLOG_MAX    = 8,
    parameter int CAS_LEAD_CYC   = 1,
    parameter int CAS_HOLD_CYC   = 2,
    parameter int RAS_LOW_CYC    = 6,
    parameter int RP_CYC         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_grant,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic backlog_ovf
);
    logic tick;
    logic take;
    logic backlog_nz;

    refresh_tick_timer #(
        .TICK_CYC(TICK_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (init_done),
        .tick (tick)
    );

    refresh_backlog #(
        .DEPTH(BACKLOG_MAX)
    ) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .take   (take),
        .nonzero(backlog_nz),
        .ovf    (backlog_ovf)
    );

    refresh_strobe_fsm #(
        .INIT_PAUSE_CYC(INIT_PAUSE_CYC),
        .WAKE_COUNT    (WAKE_COUNT),
        .CAS_LEAD_CYC  (CAS_LEAD_CYC),
        .CAS_HOLD_CYC  (CAS_HOLD_CYC),
        .RAS_LOW_CYC   (RAS_LOW_CYC),
        .RP_CYC        (RP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .backlog_nz(backlog_nz),
        .bus_grant (bus_grant),
        .bus_req   (bus_req),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .init_done (init_done),
        .take      (take)
    );
endmodule

// File: rtl/dram_refresh_sched_chk.sv
// Protocol checker for the refresh scheduler, bound to the top module.
// It watches only the ports and keeps its own strobe-width counters.
module dram_refresh_sched_chk #(
    parameter int RAS_LOW_CYC = 6,
    parameter int RP_CYC      = 4
) (
    input logic clk,
    input logic rst_n,
    input logic bus_grant,
    input logic bus_req,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic init_done,
    input logic backlog_ovf
);
    logic [7:0] ras_lo_cnt;
    logic [7:0] ras_hi_cnt;

    // Measure how long the row strobe has been low, and how long it has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= 8'hFF;
        end else if (!ras_n) begin
            ras_lo_cnt <= (ras_lo_cnt == 8'hFF) ? ras_lo_cnt : ras_lo_cnt + 8'd1;
            ras_hi_cnt <= '0;
        end else begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= (ras_hi_cnt == 8'hFF) ? ras_hi_cnt : ras_hi_cnt + 8'd1;
        end
    end

    assert_idle_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (ras_n && cas_n));

    assert_start_on_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && ras_n) |-> $past(bus_grant));

    assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    assert_cas_held_after_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !cas_n);

    assert_write_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> we_n);

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo_cnt == 8'(RAS_LOW_CYC)));

    assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && ras_n) |-> (ras_hi_cnt >= 8'(RP_CYC)));

    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        backlog_ovf |=> backlog_ovf);

    assert_no_ovf_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !backlog_ovf);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .RP_CYC     (RP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_grant  (bus_grant),
    .bus_req    (bus_req),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .init_done  (init_done),
    .backlog_ovf(backlog_ovf)
);

// File: tb/dram_refresh_sched_tb.sv
// Scoreboard bench. The driver and a tick model push expected refresh shapes into
// a queue. The monitor pops one entry per observed refresh and compares it.
module dram_refresh_sched_tb;
    localparam int CLK_PERIOD_NS = 10;
    localparam int PAUSE = 200;
    localparam int WAKE  = 8;
    localparam int TICK  = 200;
    localparam int BMAX  = 8;
    localparam int LEAD  = 1;
    localparam int HOLD  = 2;
    localparam int LOW   = 6;
    localparam int RP    = 4;

    typedef struct packed {
        logic [7:0] lead;
        logic [7:0] low;
        logic [7:0] hold;
    } shape_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_grant = 1'b0;
    logic bus_req, ras_n, cas_n, we_n, init_done, backlog_ovf;

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    dram_refresh_sched #(
        .INIT_PAUSE_CYC(PAUSE), .WAKE_COUNT(WAKE), .TICK_CYC(TICK),
        .BACKLOG_MAX(BMAX), .CAS_LEAD_CYC(LEAD), .CAS_HOLD_CYC(HOLD),
        .RAS_LOW_CYC(LOW), .RP_CYC(RP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done),
        .backlog_ovf(backlog_ovf)
    );

    int     n_checks = 0;
    int     n_errs   = 0;
    shape_t exp_q[$];
    shape_t nominal = '{lead: 8'(LEAD), low: 8'(LOW), hold: 8'(HOLD)};

    // Monitor and tick model state.
    int  cyc = 0, tc = -1, ras_falls = 0;
    int  last_fall = 0, last_rise = -1000;
    int  lead_c = 0, low_c = 0, hold_c = 0;
    int  model_pending = 0;
    bit  model_ovf = 1'b0, steady = 1'b0, in_cyc = 1'b0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Tick model plus strobe monitor, both sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; tc = -1; in_cyc = 1'b0; prev_ras = 1'b1; prev_cas = 1'b1;
            last_rise = -1000; model_pending = 0; model_ovf = 1'b0;
        end else begin
            cyc++;
            // R6: model of the periodic tick, counted from the rise of init_done.
            if (!init_done) tc = -1;
            else begin
                tc++;
                if (tc == TICK) begin
                    tc = 0;
                    if (model_pending < BMAX) begin
                        model_pending++;
                        exp_q.push_back(nominal);
                    end else model_ovf = 1'b1;
                end
            end
            if (!ras_n || !cas_n) check(we_n == 1'b1, "R4", "we_n during strobe", we_n, 1);
            if (prev_cas && !cas_n && ras_n) begin
                in_cyc = 1'b1; lead_c = 0; low_c = 0; hold_c = 0;
                check(cyc - last_rise > RP, "R5", "precharge before cas fall",
                      cyc - last_rise, RP + 1);
            end
            if (in_cyc) begin
                if (!cas_n && ras_n) lead_c++;
                if (!ras_n) low_c++;
                if (!ras_n && !cas_n) hold_c++;
            end
            if (prev_ras && !ras_n) begin
                ras_falls++;
                check(!cas_n, "R3", "cas low at ras fall", cas_n, 0);
                if (steady) check(cyc - last_fall == TICK, "R6", "refresh spacing",
                                  cyc - last_fall, TICK);
                last_fall = cyc;
            end
            if (!prev_ras && ras_n) begin
                last_rise = cyc;
                in_cyc = 1'b0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected refresh", 1, 0);
                end else begin
                    shape_t e;
                    e = exp_q.pop_front();
                    check(lead_c == int'(e.lead), "R3", "cas lead cycles", lead_c, int'(e.lead));
                    check(hold_c == int'(e.hold), "R3", "cas hold cycles", hold_c, int'(e.hold));
                    check(low_c == int'(e.low), "R5", "ras low cycles", low_c, int'(e.low));
                end
                if (init_done && model_pending > 0) model_pending--;
            end
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic wait_mid();
        @(negedge clk);
        while (tc != TICK / 2) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    // Driver: the stimulus phases.
    initial begin
        int n, f0;
        bit held;
        bus_grant = 1'b1;
        repeat (4) @(negedge clk);
        // R1: state while reset is held.
        check(ras_n && cas_n, "R1", "strobes in reset", {ras_n, cas_n}, 3);
        check(!bus_req && !init_done && !backlog_ovf, "R1", "flags in reset",
              {bus_req, init_done, backlog_ovf}, 0);
        for (int i = 0; i < WAKE; i++) exp_q.push_back(nominal);
        rst_n = 1'b1;
        n = 0;
        held = 1'b1;
        while (!bus_req) begin
            @(negedge clk);
            n++;
            if (!ras_n || !cas_n) held = 1'b0;
        end
        check(n == PAUSE, "R1", "pause length", n, PAUSE);
        check(held, "R1", "strobes high in pause", held, 1);
        // R2: wake-up refresh count.
        while (!init_done) @(negedge clk);
        check(ras_falls == WAKE, "R2", "wake refresh count", ras_falls, WAKE);
        // R6: steady spacing with the grant always given.
        while (ras_falls < WAKE + 1) @(negedge clk);
        steady = 1'b1;
        while (ras_falls < WAKE + 4) @(negedge clk);
        steady = 1'b0;
        // R7: deferral of three ticks.
        wait_mid();
        check(!bus_req, "R7", "no request when nothing owed", bus_req, 0);
        bus_grant = 1'b0;
        f0 = ras_falls;
        repeat (3 * TICK) @(negedge clk);
        check(ras_falls == f0, "R7", "no refresh without grant", ras_falls - f0, 0);
        check(bus_req, "R7", "request held while deferred", bus_req, 1);
        check(!backlog_ovf, "R8", "no overflow for short backlog", backlog_ovf, 0);
        bus_grant = 1'b1;
        f0 = ras_falls;
        repeat (40) @(negedge clk);
        check(ras_falls - f0 == 3, "R8", "backlog drained back to back", ras_falls - f0, 3);
        // R8: saturation and overflow.
        wait_mid();
        bus_grant = 1'b0;
        repeat (8 * TICK) @(negedge clk);
        check(!backlog_ovf, "R8", "full backlog without overflow", backlog_ovf, 0);
        repeat (TICK) @(negedge clk);
        check(backlog_ovf == model_ovf, "R8", "overflow on ninth tick", backlog_ovf, 1);
        bus_grant = 1'b1;
        f0 = ras_falls;
        repeat (98) @(negedge clk);
        check(ras_falls - f0 == BMAX, "R8", "saturated burst length", ras_falls - f0, BMAX);
        repeat (2 * TICK) @(negedge clk);
        wait_mid();
        check(exp_q.size() == 0, "R6", "all owed refreshes run", exp_q.size(), 0);
        check(backlog_ovf, "R8", "overflow sticky", backlog_ovf, 1);
        // R1: reset in mid-run clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        check(!init_done && !backlog_ovf && !bus_req, "R1", "flags after reset",
              {init_done, backlog_ovf, bus_req}, 0);
        check(ras_n && cas_n, "R1", "strobes after reset", {ras_n, cas_n}, 3);
        finish_up();
    end
endmodule